// File: doc/BRIEF.md
# SDR SDRAM Mode Settings and Burst Sequencer

This block is the device-side control logic of a low-power single-data-rate SDRAM. It watches the command port, stores the settings written by load-mode commands in two registers (a standard one and an extended one, told apart by the bank bits), and applies the standard settings to every read and write that follows. For each access it produces the column of every beat in the programmed order and length. Write beats are issued right away. Read beats are held back by the programmed access latency. A single-beat write option cuts every write to one element.

The extended register holds the partial-array and temperature settings used during self refresh. Their decoded form is exported: which banks keep refresh, how many upper row bits are forced to zero, and the temperature band. A register load is accepted only while the controller reports all banks idle. A load that arrives at any other time changes nothing and raises a one-cycle error pulse.

Top module: `sdr_mode_burst`

## Requirements
- R1: After reset the burst length is 1, the order is sequential, the read latency is 2, writes follow the burst length, all four banks are refreshed with no row bits dropped, and the temperature code is 00.
- R2: A load-mode command (cmd=01) with bank bits 00 while all_idle is high sets the standard register. A2..A0 give the beat count: 000=1, 001=2, 010=4, 011=8, any other code=1. A3 selects the order: 0=sequential, 1=interleaved. A6..A4=011 selects latency 3 and any other value selects latency 2. A9=1 selects single-beat writes. The new settings apply to reads and writes from the next edge onward.
- R3: A load-mode command with bank bits 10 while all_idle is high sets the extended register: A2..A0 go to the partial-array code and A4..A3 go to the temperature code (exported on sr_temp). Bank bits 01 and 11 change neither register.
- R4: A load-mode command while all_idle is low leaves both registers unchanged and drives mrs_err high for exactly the one cycle after that edge.
- R5: In sequential order, beat k uses column base + ((start mod L) + k) mod L, where L is the beat count and base is the start column rounded down to a multiple of L.
- R6: In interleaved order, beat k uses column base + ((start mod L) XOR k).
- R7: A read (cmd=10) registered at edge n drives beat k on rd_valid/rd_col right after edge n + latency + k.
- R8: A write (cmd=11) registered at edge n drives beat k on wr_valid/wr_col right after edge n + k. When single-beat writes are set, a write has exactly one beat, and reads keep the full length.
- R9: A read or write registered while a burst is still issuing ends that burst at once, and the new burst starts at its own edge. Read beats issued before that edge still come out after the latency.
- R10: The partial-array code decodes to sr_bank_mask/sr_row_drop as follows: 000 gives 1111/0, 001 gives 0011/0, 010 gives 0001/0, 101 gives 0001/1, 110 gives 0001/2. The reserved codes 011, 100 and 111 give 1111/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| all_idle | input | 1 | High when every bank is idle |
| cmd | input | 2 | 00 none, 01 load mode, 10 read, 11 write |
| cmd_ba | input | 2 | Bank bits of the command |
| cmd_addr | input | 13 | Address bits of the command (column in the low bits) |
| wr_valid | output | 1 | Write beat present |
| wr_col | output | 10 | Column of the write beat |
| rd_valid | output | 1 | Read beat present after the latency |
| rd_col | output | 10 | Column of the read beat |
| mrs_err | output | 1 | Pulse for a rejected register load |
| sr_bank_mask | output | 4 | Banks kept in self refresh |
| sr_row_drop | output | 2 | Upper row bits forced to zero in self refresh |
| sr_temp | output | 2 | Stored temperature code |

## Verification
Delayed read beats and fresh write beats can land in the same cycle, because a write may start while earlier read beats are still in the latency line. The bench provokes this with directed read-then-write pairs a cycle or two apart, and with random back-to-back reads and writes. A bench model schedules every issued beat per edge, clears the rest of a burst when it is cut short, and compares both output channels on every cycle. A burst truncated by the next command is judged the same way: the cut read beats must never appear, and the beats already launched must still appear.

// File: rtl/sdrmb_pkg.sv
package sdrmb_pkg;

   typedef enum logic [1:0] {
      CMD_NOP = 2'b00,
      CMD_MRS = 2'b01,
      CMD_RD  = 2'b10,
      CMD_WR  = 2'b11
   } cmd_e;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;

   typedef struct packed {
      logic [3:0] beats;
      order_e     order;
      logic [1:0] lat;
      logic       wr_single;
   } std_mode_t;

   typedef struct packed {
      logic [2:0] pasr;
      logic [1:0] temp;
   } ext_mode_t;

   localparam std_mode_t STD_RESET = '{beats: 4'd1, order: ORD_SEQ, lat: 2'd2, wr_single: 1'b0};
   localparam ext_mode_t EXT_RESET = '{pasr: 3'b000, temp: 2'b00};

   function automatic logic [3:0] beats_of(input logic [2:0] code);
      case (code)
         3'b000:  return 4'd1;
         3'b001:  return 4'd2;
         3'b010:  return 4'd4;
         3'b011:  return 4'd8;
         default: return 4'd1;
      endcase
   endfunction

endpackage

// File: rtl/sdrmb_modereg.sv
module sdrmb_modereg
   import sdrmb_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              all_idle,
   input  logic [1:0]        cmd,
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   output std_mode_t         std_q,
   output ext_mode_t         ext_q,
   output logic              err_q,
   output logic [3:0]        bank_mask,
   output logic [1:0]        row_drop
);

   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("sdrmb_modereg: ADDR_W must reach bit 9");
      end
   endgenerate

   logic is_mrs;
   logic accept;

   assign is_mrs = (cmd == CMD_MRS);
   assign accept = is_mrs && all_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         std_q <= STD_RESET;
         ext_q <= EXT_RESET;
         err_q <= 1'b0;
      end else begin
         err_q <= is_mrs && !all_idle;
         if (accept && ba == 2'b00) begin
            std_q.beats     <= beats_of(addr[2:0]);
            std_q.order     <= order_e'(addr[3]);
            std_q.lat       <= (addr[6:4] == 3'b011) ? 2'd3 : 2'd2;
            std_q.wr_single <= addr[9];
         end
         if (accept && ba == 2'b10) begin
            ext_q.pasr <= addr[2:0];
            ext_q.temp <= addr[4:3];
         end
      end
   end

   always_comb begin
      bank_mask = 4'b1111;
      row_drop  = 2'd0;
      case (ext_q.pasr)
         3'b001: bank_mask = 4'b0011;
         3'b010: bank_mask = 4'b0001;
         3'b101: begin bank_mask = 4'b0001; row_drop = 2'd1; end
         3'b110: begin bank_mask = 4'b0001; row_drop = 2'd2; end
         default: ;
      endcase
   end

   // R4: a rejected load pulses the error and leaves both registers alone
   assert_mrs_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && !all_idle) |=> (err_q && $stable(std_q) && $stable(ext_q)));

   // R3: accepted extended load stores the address fields
   assert_ext_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ba == 2'b10) |=> (ext_q.pasr == $past(addr[2:0]) && ext_q.temp == $past(addr[4:3])));

endmodule

// File: rtl/sdrmb_burst_gen.sv
module sdrmb_burst_gen
   import sdrmb_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_rd,
   input  logic [COL_W-1:0] start_col,
   input  logic [3:0]       beats,
   input  order_e           order,
   input  logic             wr_single,
   output logic             beat_valid,
   output logic             beat_rd,
   output logic [COL_W-1:0] beat_col
);

   generate
      if (COL_W < 3) begin : g_bad_col
         $error("sdrmb_burst_gen: COL_W must cover an eight-beat block");
      end
   endgenerate

   localparam int OFF_W = 3;

   logic [3:0]       eff_beats;
   logic [OFF_W-1:0] mask;
   logic [COL_W-1:0] mask_w;

   logic [COL_W-1:0] base_q;
   logic [OFF_W-1:0] off_q, mask_q, rem_q, idx_q;
   logic             ilv_q;
   logic [OFF_W-1:0] next_off;

   assign eff_beats = (!start_rd && wr_single) ? 4'd1 : beats;
   assign mask      = OFF_W'(eff_beats - 4'd1);
   assign mask_w    = {{(COL_W-OFF_W){1'b0}}, mask};
   assign next_off  = ilv_q ? ((off_q ^ idx_q) & mask_q) : ((off_q + idx_q) & mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_valid <= 1'b0;
         beat_rd    <= 1'b0;
         beat_col   <= '0;
         base_q     <= '0;
         off_q      <= '0;
         mask_q     <= '0;
         rem_q      <= '0;
         idx_q      <= '0;
         ilv_q      <= 1'b0;
      end else if (start) begin
         beat_valid <= 1'b1;
         beat_rd    <= start_rd;
         beat_col   <= start_col;
         base_q     <= start_col & ~mask_w;
         off_q      <= start_col[OFF_W-1:0] & mask;
         mask_q     <= mask;
         rem_q      <= mask;
         idx_q      <= 3'd1;
         ilv_q      <= (order == ORD_ILV);
      end else if (rem_q != '0) begin
         beat_valid <= 1'b1;
         beat_col   <= base_q | {{(COL_W-OFF_W){1'b0}}, next_off};
         rem_q      <= rem_q - 3'd1;
         idx_q      <= idx_q + 3'd1;
      end else begin
         beat_valid <= 1'b0;
      end
   end

   // R8: beat zero lands on the start column in the edge of the command
   assert_first_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (beat_valid && beat_col == $past(start_col)));

   // R9: a burst with no beats left and no new command stops issuing
   assert_burst_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && rem_q == '0 && !start) |=> !beat_valid);

   // R8: single-beat write mode leaves nothing after beat zero
   assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !start_rd && wr_single) |=> (rem_q == '0));

endmodule

// File: rtl/sdrmb_lat_pipe.sv
module sdrmb_lat_pipe #(
   parameter int W       = 10,
   parameter int MAX_LAT = 3,
   localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] lat,
   input  logic             in_valid,
   input  logic [W-1:0]     in_data,
   output logic             out_valid,
   output logic [W-1:0]     out_data
);

   generate
      if (MAX_LAT < 3) begin : g_bad_lat
         $error("sdrmb_lat_pipe: MAX_LAT must allow a latency of 3");
      end
   endgenerate

   logic         v [1:MAX_LAT];
   logic [W-1:0] d [1:MAX_LAT];

   generate
      for (genvar i = 1; i <= MAX_LAT; i++) begin : g_stage
         if (i == 1) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  v[i] <= 1'b0;
                  d[i] <= '0;
               end else begin
                  v[i] <= in_valid;
                  d[i] <= in_data;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  v[i] <= 1'b0;
                  d[i] <= '0;
               end else begin
                  v[i] <= v[i-1];
                  d[i] <= d[i-1];
               end
            end
         end
      end
   endgenerate

   always_comb begin
      out_valid = 1'b0;
      out_data  = '0;
      for (int i = 1; i <= MAX_LAT; i++) begin
         if (lat == LAT_W'(i)) begin
            out_valid = v[i];
            out_data  = d[i];
         end
      end
   end

endmodule

// File: rtl/sdr_mode_burst.sv
module sdr_mode_burst
   import sdrmb_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter int ADDR_W  = 13,
   parameter int MAX_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              all_idle,
   input  logic [1:0]        cmd,
   input  logic [1:0]        cmd_ba,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              wr_valid,
   output logic [COL_W-1:0]  wr_col,
   output logic              rd_valid,
   output logic [COL_W-1:0]  rd_col,
   output logic              mrs_err,
   output logic [3:0]        sr_bank_mask,
   output logic [1:0]        sr_row_drop,
   output logic [1:0]        sr_temp
);

   localparam int LAT_W = $clog2(MAX_LAT + 1);

   generate
      if (COL_W > ADDR_W) begin : g_bad_widths
         $error("sdr_mode_burst: column wider than address bus");
      end
   endgenerate

   std_mode_t        std_q;
   ext_mode_t        ext_q;
   logic             start, start_rd;
   logic             g_valid, g_rd;
   logic [COL_W-1:0] g_col;

   assign start    = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign start_rd = (cmd == CMD_RD);

   sdrmb_modereg #(.ADDR_W(ADDR_W)) u_modereg (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_idle  (all_idle),
      .cmd       (cmd),
      .ba        (cmd_ba),
      .addr      (cmd_addr),
      .std_q     (std_q),
      .ext_q     (ext_q),
      .err_q     (mrs_err),
      .bank_mask (sr_bank_mask),
      .row_drop  (sr_row_drop)
   );

   sdrmb_burst_gen #(.COL_W(COL_W)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_rd   (start_rd),
      .start_col  (cmd_addr[COL_W-1:0]),
      .beats      (std_q.beats),
      .order      (std_q.order),
      .wr_single  (std_q.wr_single),
      .beat_valid (g_valid),
      .beat_rd    (g_rd),
      .beat_col   (g_col)
   );

   sdrmb_lat_pipe #(.W(COL_W), .MAX_LAT(MAX_LAT)) u_rdpipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat       (LAT_W'(std_q.lat)),
      .in_valid  (g_valid && g_rd),
      .in_data   (g_col),
      .out_valid (rd_valid),
      .out_data  (rd_col)
   );

   assign wr_valid = g_valid && !g_rd;
   assign wr_col   = g_col;
   assign sr_temp  = ext_q.temp;

endmodule

// File: tb/sdr_mode_burst_tb.sv
module sdr_mode_burst_tb_top;

   localparam int NSLOT = 8200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        all_idle = 1'b1;
   logic [1:0]  cmd = 2'b00;
   logic [1:0]  cmd_ba = 2'b00;
   logic [12:0] cmd_addr = '0;
   logic        wr_valid, rd_valid, mrs_err;
   logic [9:0]  wr_col, rd_col;
   logic [3:0]  sr_bank_mask;
   logic [1:0]  sr_row_drop, sr_temp;

   always #2.5 clk = ~clk;

   sdr_mode_burst dut_i (
      .clk(clk), .rst_n(rst_n), .all_idle(all_idle), .cmd(cmd), .cmd_ba(cmd_ba),
      .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_col(wr_col), .rd_valid(rd_valid),
      .rd_col(rd_col), .mrs_err(mrs_err), .sr_bank_mask(sr_bank_mask),
      .sr_row_drop(sr_row_drop), .sr_temp(sr_temp)
   );

   int    checks = 0;
   int    fails = 0;
   int    edge_n = 0;
   int    wd = 0;
   string tag = "R1";

   // beat schedule per edge
   bit         g_v  [0:NSLOT-1];
   bit         g_rd [0:NSLOT-1];
   logic [9:0] g_c  [0:NSLOT-1];

   // model of the stored settings
   int   m_len = 1, m_cl = 2;
   bit   m_ilv = 0, m_single = 0;
   logic [2:0] m_pasr = 3'b000;
   logic [1:0] m_temp = 2'b00;

   function automatic int len_fn(input logic [2:0] code);
      if (code <= 3'd3) return 1 << code;
      return 1;
   endfunction

   function automatic logic [9:0] col_fn(input int start, input int len, input bit ilv, input int k);
      int base, off;
      base = (start / len) * len;
      off  = start % len;
      if (ilv) return 10'(base + (off ^ k));
      return 10'(base + ((off + k) % len));
   endfunction

   function automatic logic [5:0] sr_fn(input logic [2:0] p);
      case (p)
         3'b000: return {4'b1111, 2'd0};
         3'b001: return {4'b0011, 2'd0};
         3'b010: return {4'b0001, 2'd0};
         3'b101: return {4'b0001, 2'd1};
         3'b110: return {4'b0001, 2'd2};
         default: return {4'b1111, 2'd0};
      endcase
   endfunction

   task automatic check(input string rq, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s [%s] %s: got %0d expected %0d", rq, tag, what, got, exp);
      end
   endtask

   // drive one command, advance one edge, check all outputs for that edge
   task automatic tick(input logic [1:0] c, input logic [1:0] ba, input logic [12:0] a, input logic idle);
      int  e, len, lat;
      bit  ev, erv;
      logic [5:0] sr;
      e = edge_n;
      cmd = c; cmd_ba = ba; cmd_addr = a; all_idle = idle;
      if (c == 2'b10 || c == 2'b11) begin
         len = (c == 2'b11 && m_single) ? 1 : m_len;
         for (int t = e; t < e + 8; t++) g_v[t] = 1'b0;   // R9 truncation
         for (int k = 0; k < len; k++) begin
            g_v[e+k]  = 1'b1;
            g_rd[e+k] = (c == 2'b10);
            g_c[e+k]  = col_fn(int'(a[9:0]), len, m_ilv, k);
         end
      end
      if (c == 2'b01 && idle) begin
         if (ba == 2'b00) begin
            m_len = len_fn(a[2:0]); m_ilv = a[3];
            m_cl = (a[6:4] == 3'b011) ? 3 : 2; m_single = a[9];
         end else if (ba == 2'b10) begin
            m_pasr = a[2:0]; m_temp = a[4:3];
         end
      end
      @(posedge clk);
      @(negedge clk);
      lat = m_cl;
      // R8 write channel
      ev = g_v[e] && !g_rd[e];
      check("R8", "wr_valid", int'(wr_valid), int'(ev));
      if (ev) check("R8", "wr_col", int'(wr_col), int'(g_c[e]));
      // R7 read channel
      erv = (e >= lat) && g_v[e-lat] && g_rd[e-lat];
      check("R7", "rd_valid", int'(rd_valid), int'(erv));
      if (erv) check("R7", "rd_col", int'(rd_col), int'(g_c[e-lat]));
      // R4 error pulse
      check("R4", "mrs_err", int'(mrs_err), int'(c == 2'b01 && !idle));
      // R10 / R3 decoded status
      sr = sr_fn(m_pasr);
      check("R10", "sr_bank_mask", int'(sr_bank_mask), int'(sr[5:2]));
      check("R10", "sr_row_drop", int'(sr_row_drop), int'(sr[1:0]));
      check("R3", "sr_temp", int'(sr_temp), int'(m_temp));
      edge_n++;
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) tick(2'b00, 2'b00, 13'd0, 1'b1);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected under 150000", wd);
         finish_run();
      end
   end

   initial begin
      for (int t = 0; t < NSLOT; t++) begin g_v[t] = 1'b0; g_rd[t] = 1'b0; g_c[t] = '0; end
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state at the ports
      tag = "R1";
      check("R1", "reset wr_valid", int'(wr_valid), 0);
      check("R1", "reset rd_valid", int'(rd_valid), 0);
      check("R1", "reset sr_bank_mask", int'(sr_bank_mask), 15);
      check("R1", "reset sr_temp", int'(sr_temp), 0);
      tick(2'b10, 2'b00, 13'd5, 1'b1);     // R1 default: one beat at latency 2
      tick(2'b11, 2'b00, 13'd9, 1'b1);     // R1 default write length 1
      idle_n(6);

      // R2 / R5: four beats, sequential, latency 3
      tag = "R5";
      tick(2'b01, 2'b00, 13'h032, 1'b1);
      tick(2'b10, 2'b00, 13'd6, 1'b1);
      idle_n(8);
      tick(2'b11, 2'b00, 13'd3, 1'b1);
      idle_n(6);

      // R2 / R6: eight beats, interleaved, latency 2
      tag = "R6";
      tick(2'b01, 2'b00, 13'h02B, 1'b1);
      tick(2'b11, 2'b00, 13'd13, 1'b1);
      idle_n(9);
      tick(2'b10, 2'b00, 13'd21, 1'b1);
      idle_n(12);

      // R8: single-beat writes, reads stay at full length
      tag = "R8";
      tick(2'b01, 2'b00, 13'h22B, 1'b1);
      tick(2'b11, 2'b00, 13'd14, 1'b1);
      idle_n(3);
      tick(2'b10, 2'b00, 13'd14, 1'b1);
      idle_n(12);

      // R9: truncation and read beats overlapping a new write
      tag = "R9";
      tick(2'b01, 2'b00, 13'h033, 1'b1);  // eight beats sequential latency 3
      tick(2'b10, 2'b00, 13'd2, 1'b1);
      tick(2'b00, 2'b00, 13'd0, 1'b1);
      tick(2'b11, 2'b00, 13'd40, 1'b1);
      tick(2'b00, 2'b00, 13'd0, 1'b1);
      tick(2'b10, 2'b00, 13'd17, 1'b1);
      idle_n(12);

      // R4: load while banks busy is ignored
      tag = "R4";
      tick(2'b01, 2'b00, 13'h000, 1'b0);
      tick(2'b01, 2'b10, 13'h00D, 1'b0);
      tick(2'b10, 2'b00, 13'd3, 1'b1);     // still eight beats
      idle_n(12);

      // R2: reserved length code gives one beat
      tag = "R2";
      tick(2'b01, 2'b00, 13'h025, 1'b1);
      tick(2'b10, 2'b00, 13'd7, 1'b1);
      idle_n(5);

      // R3 / R10: every partial-array code, temperature codes, ignored bank codes
      tag = "R10";
      for (int p = 0; p < 8; p++) begin
         tick(2'b01, 2'b10, 13'((p % 3) << 3 | p), 1'b1);
         idle_n(1);
      end
      tag = "R3";
      tick(2'b01, 2'b01, 13'h01F, 1'b1);
      tick(2'b01, 2'b11, 13'h01F, 1'b1);
      idle_n(2);

      // random phase
      tag = "RND";
      for (int i = 0; i < 700; i++) begin
         int r;
         r = int'($urandom_range(0, 9));
         if (r == 0) begin
            idle_n(12);
            tick(2'b01, 2'($urandom_range(0, 3)), 13'($urandom), ($urandom_range(0, 3) != 0));
         end else if (r <= 4) begin
            tick(2'b10, 2'($urandom), 13'($urandom), 1'($urandom));
         end else if (r <= 7) begin
            tick(2'b11, 2'($urandom), 13'($urandom), 1'($urandom));
         end else begin
            tick(2'b00, 2'b00, 13'd0, 1'b1);
         end
      end
      idle_n(12);
      finish_run();
   end

endmodule